// File: doc/BRIEF.md
# Transmit FIFO Space Status Generator

This block sits on the transmit side of a multi-port PHY-to-link packet interface and tells the link layer which ports can accept more packet data. For each port it receives the current fill level of that port's transmit FIFO, a full indication and a programmable space threshold. From these it keeps one registered space-available flag per port. The flag rises once the free room exceeds the threshold and falls when the FIFO reports full. Between those two conditions the flag keeps its value, which gives hysteresis.

The link layer reads the same per-port flag in three ways. The direct flags are one output bit per port. The polled flag reports the port whose address the link layer drove on the poll address input in the previous cycle. The selected flag reports the port that is currently chosen for data transfer. That choice is captured from the low five bits of the transmit data bus in any cycle where the start-of-transfer strobe is high. Everything is sampled and updated on the rising edge of one transmit system clock. The FIFO storage and the line-side logic are outside this block.

Top module: `txsp_status`

## Requirements
- R1: While `rst_n` is low at a rising edge, every direct flag is cleared, the registered poll address becomes 0 and the selected port becomes port 0, so after reset `direct_avail`, `poll_avail` and `sel_avail` are all 0.
- R2: At a rising edge where a port's `fifo_full` is low and its free space (`FIFO_BYTES` minus its `fill_lvl` field) is strictly greater than its `space_thr` field, that port's direct flag becomes 1. Port p's fields occupy bits `[p*LVL_W +: LVL_W]`.
- R3: At a rising edge where a port's `fifo_full` is high, its direct flag becomes 0, whatever the threshold comparison gives.
- R4: At a rising edge where a port's `fifo_full` is low and its free space is less than or equal to its threshold, its direct flag keeps its previous value.
- R5: After each rising edge, `poll_avail` equals the direct flag of the port whose number was on `poll_addr` at that edge, or 0 if that number is not below `NUM_PORTS`.
- R6: At a rising edge with `sot_strobe` high and `tx_data[4:0]` below `NUM_PORTS`, that value becomes the selected port. `sel_avail` always equals the direct flag of the selected port.
- R7: A start-of-transfer strobe whose `tx_data[4:0]` is `NUM_PORTS` or higher leaves the selected port unchanged.
- R8: With `sot_strobe` low, the contents of `tx_data` have no effect on the selected port.
- R9: After reset, `poll_avail` and `sel_avail` are always driven to a known 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit system clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fill_lvl | input | NUM_PORTS*LVL_W | Per-port transmit FIFO fill level in bytes |
| fifo_full | input | NUM_PORTS | Per-port FIFO full indication |
| space_thr | input | NUM_PORTS*LVL_W | Per-port free-space threshold in bytes |
| poll_addr | input | 5 | Address of the port being polled |
| sot_strobe | input | 1 | Start-of-transfer strobe; `tx_data` carries a port address |
| tx_data | input | DATA_W | Transmit data bus |
| direct_avail | output | NUM_PORTS | Per-port space-available flags |
| poll_avail | output | 1 | Space flag of the polled port |
| sel_avail | output | 1 | Space flag of the selected port |

## Verification
The hardest state to reach from the ports is a port sitting in the hysteresis band. Its fill level must be brought there from above the threshold on one visit and from the full state on another, while poll and select cycles address that same port in the same clocks. The stimulus therefore picks, for each port and each cycle, one of three regions: full, clear room, or the band between them. It draws thresholds anew, so the band is entered from both sides. Poll addresses and strobe addresses are drawn half outside the port range, and the data bus keeps changing while the strobe is low. A mid-run reset confirms that the flags and the selection return to their initial state.

// File: rtl/txsp_pkg.sv
// Package: shared constants for the transmit space status block.
// Assumes: port addresses travel as five-bit values on both the poll
// input and the low bits of the transmit data bus.
package txsp_pkg;
    parameter int unsigned PORT_ADDR_W = 5;
endpackage

// File: rtl/txsp_space_flag.sv
// Module: txsp_space_flag
// Keeps one port's space-available flag with hysteresis. The flag is set
// when free room exceeds the threshold and cleared when the FIFO is full.
// In between it holds its value.
// Assumes: fill never exceeds FIFO_BYTES; full takes priority.
module txsp_space_flag #(
    parameter int unsigned FIFO_BYTES = 256,
    parameter int unsigned LVL_W      = $clog2(FIFO_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] fill,
    input  logic             full,
    input  logic [LVL_W-1:0] thr,
    output logic             avail
);
    localparam logic [LVL_W-1:0] CAP = LVL_W'(FIFO_BYTES);

    logic [LVL_W-1:0] room;
    logic             above;

    // free room and its comparison against the threshold
    always_comb begin
        room  = CAP - fill;
        above = (room > thr);
    end

    // flag register: full clears, room above threshold sets, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            avail <= 1'b0;
        end else if (full) begin
            avail <= 1'b0;
        end else if (above) begin
            avail <= 1'b1;
        end
    end
endmodule

// File: rtl/txsp_port_track.sv
// Module: txsp_port_track
// Registers the polled port address and captures the selected port from
// the data bus during a start-of-transfer cycle.
// Assumes: an out-of-range poll address reads as no space; an
// out-of-range strobe address keeps the previous selection.
module txsp_port_track
    import txsp_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned PSEL_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [PORT_ADDR_W-1:0] poll_addr,
    input  logic                   sot_strobe,
    input  logic [DATA_W-1:0]      tx_data,
    output logic [PSEL_W-1:0]      poll_idx,
    output logic                   poll_ok,
    output logic [PSEL_W-1:0]      sel_idx
);
    localparam logic [PORT_ADDR_W-1:0] PORT_LIMIT = PORT_ADDR_W'(NUM_PORTS);

    logic [PORT_ADDR_W-1:0] bus_addr;
    logic                   bus_ok;
    logic                   poll_in_range;

    // address decode from the bus and the poll input
    always_comb begin
        bus_addr      = tx_data[PORT_ADDR_W-1:0];
        bus_ok        = (bus_addr < PORT_LIMIT);
        poll_in_range = (poll_addr < PORT_LIMIT);
    end

    // poll address register, sampled every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            poll_idx <= '0;
            poll_ok  <= 1'b1;
        end else begin
            poll_idx <= poll_addr[PSEL_W-1:0];
            poll_ok  <= poll_in_range;
        end
    end

    // selected port register, loaded only on a valid strobe address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_idx <= '0;
        end else if (sot_strobe && bus_ok) begin
            sel_idx <= bus_addr[PSEL_W-1:0];
        end
    end
endmodule

// File: rtl/txsp_status.sv
// Module: txsp_status (top)
// Builds one hysteresis flag per port, exposes them directly, and
// derives the polled and selected views from the tracked addresses.
// Assumes: one clock domain; the polled and selected outputs are always
// driven.
module txsp_status
    import txsp_pkg::*;
#(
    parameter int unsigned NUM_PORTS  = 4,
    parameter int unsigned FIFO_BYTES = 256,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned LVL_W      = $clog2(FIFO_BYTES + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_PORTS*LVL_W-1:0] fill_lvl,
    input  logic [NUM_PORTS-1:0]       fifo_full,
    input  logic [NUM_PORTS*LVL_W-1:0] space_thr,
    input  logic [PORT_ADDR_W-1:0]     poll_addr,
    input  logic                       sot_strobe,
    input  logic [DATA_W-1:0]          tx_data,
    output logic [NUM_PORTS-1:0]       direct_avail,
    output logic                       poll_avail,
    output logic                       sel_avail
);
    localparam int unsigned PSEL_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

    logic [PSEL_W-1:0] poll_idx;
    logic              poll_ok;
    logic [PSEL_W-1:0] sel_idx;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        txsp_space_flag #(
            .FIFO_BYTES (FIFO_BYTES),
            .LVL_W      (LVL_W)
        ) u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .fill  (fill_lvl[p*LVL_W +: LVL_W]),
            .full  (fifo_full[p]),
            .thr   (space_thr[p*LVL_W +: LVL_W]),
            .avail (direct_avail[p])
        );
    end

    txsp_port_track #(
        .NUM_PORTS (NUM_PORTS),
        .DATA_W    (DATA_W),
        .PSEL_W    (PSEL_W)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .poll_addr  (poll_addr),
        .sot_strobe (sot_strobe),
        .tx_data    (tx_data),
        .poll_idx   (poll_idx),
        .poll_ok    (poll_ok),
        .sel_idx    (sel_idx)
    );

    // polled and selected views of the direct flags
    always_comb begin
        poll_avail = poll_ok & direct_avail[poll_idx];
        sel_avail  = direct_avail[sel_idx];
    end
endmodule

// File: rtl/txsp_checker.sv
// Module: txsp_checker
// Temporal properties on the ports of txsp_status, attached by bind.
// Assumes: the same parameter values as the bound instance.
module txsp_checker
    import txsp_pkg::*;
#(
    parameter int unsigned NUM_PORTS  = 4,
    parameter int unsigned FIFO_BYTES = 256,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned LVL_W      = $clog2(FIFO_BYTES + 1)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_PORTS*LVL_W-1:0] fill_lvl,
    input logic [NUM_PORTS-1:0]       fifo_full,
    input logic [NUM_PORTS*LVL_W-1:0] space_thr,
    input logic [PORT_ADDR_W-1:0]     poll_addr,
    input logic                       sot_strobe,
    input logic [DATA_W-1:0]          tx_data,
    input logic [NUM_PORTS-1:0]       direct_avail,
    input logic                       poll_avail,
    input logic                       sel_avail
);
    localparam int unsigned PSEL_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
    localparam logic [LVL_W-1:0] CAP = LVL_W'(FIFO_BYTES);
    localparam logic [PORT_ADDR_W-1:0] LIMIT = PORT_ADDR_W'(NUM_PORTS);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        logic [LVL_W-1:0] c_room;
        logic [LVL_W-1:0] c_thr;
        assign c_room = CAP - fill_lvl[p*LVL_W +: LVL_W];
        assign c_thr  = space_thr[p*LVL_W +: LVL_W];

        p_set_on_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!fifo_full[p] && (c_room > c_thr)) |=> direct_avail[p]);

        p_clear_on_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
            fifo_full[p] |=> !direct_avail[p]);

        p_hold_in_band_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!fifo_full[p] && (c_room <= c_thr)) |=> $stable(direct_avail[p]));
    end

    p_poll_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_addr < LIMIT) |=>
            (poll_avail == direct_avail[$past(poll_addr[PSEL_W-1:0])]));

    p_poll_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_addr >= LIMIT) |=> !poll_avail);

    p_sel_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sot_strobe && (tx_data[PORT_ADDR_W-1:0] < LIMIT)) |=>
            (sel_avail == direct_avail[$past(tx_data[PSEL_W-1:0])]));

    p_outputs_known_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown({poll_avail, sel_avail}));
endmodule

bind txsp_status txsp_checker #(
    .NUM_PORTS  (NUM_PORTS),
    .FIFO_BYTES (FIFO_BYTES),
    .DATA_W     (DATA_W),
    .LVL_W      (LVL_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fill_lvl     (fill_lvl),
    .fifo_full    (fifo_full),
    .space_thr    (space_thr),
    .poll_addr    (poll_addr),
    .sot_strobe   (sot_strobe),
    .tx_data      (tx_data),
    .direct_avail (direct_avail),
    .poll_avail   (poll_avail),
    .sel_avail    (sel_avail)
);

// File: tb/txsp_status_tb.sv
// Bench for txsp_status: a behavioural reference model updated at each
// rising edge, compared with the outputs at every falling edge.
module txsp_status_tb;
    localparam int NP     = 4;
    localparam int CAPB   = 256;
    localparam int LW     = 9;
    localparam int DW     = 32;
    localparam int CLK_PERIOD = 10;
    localparam int N_CYC  = 4000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NP*LW-1:0] fill_lvl = '0;
    logic [NP-1:0]    fifo_full = '0;
    logic [NP*LW-1:0] space_thr = '0;
    logic [4:0]       poll_addr = '0;
    logic             sot_strobe = 1'b0;
    logic [DW-1:0]    tx_data = '0;
    logic [NP-1:0]    direct_avail;
    logic             poll_avail;
    logic             sel_avail;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference model state
    int    m_dir [NP];
    int    m_poll;
    int    m_sel;
    string m_why [NP];
    string m_sel_why;

    txsp_status #(.NUM_PORTS(NP), .FIFO_BYTES(CAPB), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .fill_lvl(fill_lvl), .fifo_full(fifo_full),
        .space_thr(space_thr), .poll_addr(poll_addr), .sot_strobe(sot_strobe),
        .tx_data(tx_data), .direct_avail(direct_avail), .poll_avail(poll_avail),
        .sel_avail(sel_avail)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural model of the requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NP; i++) begin m_dir[i] = 0; m_why[i] = "R1"; end
            m_poll = 0; m_sel = 0; m_sel_why = "R1";
        end else begin
            for (int i = 0; i < NP; i++) begin
                int fl, th, room;
                fl = int'(fill_lvl[i*LW +: LW]);
                th = int'(space_thr[i*LW +: LW]);
                room = CAPB - fl;
                if (fifo_full[i]) begin m_dir[i] = 0; m_why[i] = "R3"; end
                else if (room > th) begin m_dir[i] = 1; m_why[i] = "R2"; end
                else m_why[i] = "R4";
            end
            m_poll = int'(poll_addr);
            if (sot_strobe) begin
                if (int'(tx_data[4:0]) < NP) begin
                    m_sel = int'(tx_data[4:0]); m_sel_why = "R6";
                end else m_sel_why = "R7";
            end else m_sel_why = "R8";
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        int ep;
        for (int i = 0; i < NP; i++)
            chk(int'(direct_avail[i]) == m_dir[i], m_why[i], $sformatf("direct[%0d]", i),
                int'(direct_avail[i]), m_dir[i]);
        ep = (m_poll < NP) ? m_dir[m_poll] : 0;
        chk(int'(poll_avail) == ep, "R5", "poll_avail", int'(poll_avail), ep);
        chk(int'(sel_avail) == m_dir[m_sel], m_sel_why, "sel_avail",
            int'(sel_avail), m_dir[m_sel]);
        chk(!$isunknown({poll_avail, sel_avail}), "R9", "known outputs",
            int'({poll_avail, sel_avail}), 0);
    endtask

    task automatic drive_random();
        for (int i = 0; i < NP; i++) begin
            int th, mode, fl, room;
            th = int'($urandom_range(0, CAPB - 1));
            mode = int'($urandom_range(0, 2));
            if (mode == 0) begin
                fl = int'($urandom_range(0, 3)) == 0 ? int'($urandom_range(0, CAPB)) : CAPB;
                fifo_full[i] = 1'b1;
            end else if (mode == 1) begin
                room = int'($urandom_range(th + 1, CAPB));
                fl = CAPB - room;
                fifo_full[i] = 1'b0;
            end else begin
                room = int'($urandom_range(0, th));
                fl = CAPB - room;
                fifo_full[i] = 1'b0;
            end
            fill_lvl[i*LW +: LW]  = LW'(fl);
            space_thr[i*LW +: LW] = LW'(th);
        end
        poll_addr  = ($urandom_range(0, 1) == 0) ? 5'($urandom_range(0, NP - 1))
                                                 : 5'($urandom_range(0, 31));
        sot_strobe = ($urandom_range(0, 3) == 0);
        tx_data    = DW'($urandom());
        tx_data[4:0] = ($urandom_range(0, 1) == 0) ? 5'($urandom_range(0, NP - 1))
                                                   : 5'($urandom_range(0, 31));
    endtask

    // watchdog
    initial begin
        repeat (N_CYC + 200) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(direct_avail == '0, "R1", "direct after reset", int'(direct_avail), 0);
        chk(poll_avail == 1'b0, "R1", "poll after reset", int'(poll_avail), 0);
        chk(sel_avail == 1'b0, "R1", "sel after reset", int'(sel_avail), 0);
        rst_n = 1'b1;
        for (int c = 0; c < N_CYC; c++) begin
            @(negedge clk);
            compare_all();
            if (c == N_CYC / 2) rst_n = 1'b0;
            if (c == N_CYC / 2 + 2) rst_n = 1'b1;
            drive_random();
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule